// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This block carries out one atomic update of a word held in a small local memory for each request it accepts. A request names a word address, an operation code, a primary operand, a swap value (used only by compare-and-swap), a width select, a signedness bit and a flag that asks for the old contents to be sent back. The unit reads the word, forms the new value, writes it back and, when asked, reports the value the word held before the update.

Only one request is in flight at a time. After acceptance the unit spends one cycle reading, one computing and one writing, then accepts again. Compare-and-swap traffic is tallied in two free-running counters: attempts and mismatches. While a transactional mode input is high, each compare-and-swap also emits a one-cycle clear strobe toward an external tracking table. Unsupported codes raise a one-cycle error strobe and leave memory, counters and the response port untouched.

Top module: `atomic_rmw_unit`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid`, `err_pulse` and `tbl_clr` are 0, both counters read 0, and every memory word holds 0.
- R2: Operation codes are 0 AND, 1 OR, 2 XOR, 3 compare-and-swap, 4 exchange, 5 add, 6 subtract, 7 increment, 8 decrement, 9 max, 10 min. The bitwise ops, exchange, add and subtract combine the stored word with `req_opnd`. Add and subtract wrap modulo 2^width.
- R3: Compare-and-swap writes `req_swap` only when the stored word equals `req_opnd`. On a mismatch the word is unchanged.
- R4: Every compare-and-swap adds one to `cas_tries`. A mismatching one also adds one to `cas_fails`. Both counters change on the edge that ends the write cycle.
- R5: Increment adds exactly 1 and decrement subtracts exactly 1, wrapping. Both ignore `req_opnd`.
- R6: Max replaces the word only when the operand is strictly greater, and min only when it is strictly less. The comparison is two's-complement when `req_signed` is 1 and unsigned otherwise.
- R7: With `req_wide` = 0, only bits [31:0] take part in the operation and in comparisons, where bit 31 is the sign. Bits [63:32] of the stored word are preserved. With `req_wide` = 1, all 64 bits are used.
- R8: A request with `req_ret` = 1 produces `rsp_valid` high for exactly one cycle, three clock edges after the accepting edge. `rsp_data` then carries the old word: all 64 bits when wide, or bits [31:0] zero-extended when narrow. A request with `req_ret` = 0 produces no response.
- R9: A code of 11 to 15 is rejected. `err_pulse` is high for the one cycle after the accepting edge, with `req_ready` high and no response. No word is written and the counters do not move.
- R10: `tbl_clr` pulses for one cycle, in the same cycle as the response slot, for each compare-and-swap that completes while `txn_cas_mode` is 1. It never pulses otherwise.
- R11: `req_ready` is 0 from the edge that accepts a legal request until the write completes. A request is taken on an edge where `req_valid` and `req_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to accept |
| req_op | input | 4 | Operation code |
| req_addr | input | ADDR_W | Word address |
| req_opnd | input | 64 | Primary operand, or compare value for CAS |
| req_swap | input | 64 | Value written by a matching CAS |
| req_wide | input | 1 | 1 = 64-bit, 0 = 32-bit |
| req_signed | input | 1 | Signed compare for max/min |
| req_ret | input | 1 | Return the pre-operation value |
| txn_cas_mode | input | 1 | Enables the table clear strobe on CAS |
| rsp_valid | output | 1 | Old value present on rsp_data |
| rsp_data | output | 64 | Pre-operation word |
| err_pulse | output | 1 | Unsupported code was rejected |
| tbl_clr | output | 1 | Clear strobe for the external tracking table |
| cas_tries | output | CNT_W | Compare-and-swap attempt count |
| cas_fails | output | CNT_W | Compare-and-swap mismatch count |

## Verification
The properties assume that `txn_cas_mode` stays steady for the whole time a request is in flight. They also assume that the counters never wrap within the run. The bench drives each request only while the unit is idle and holds the mode input from before acceptance until after the response slot. It issues far fewer compare-and-swaps than the counter range. Random traffic stays on eight addresses so that words are revisited, and a share of it uses illegal codes and narrow widths.

// File: rtl/amo_pkg.sv
package amo_pkg;

    localparam int WORD_W = 64;
    localparam int HALF_W = 32;
    localparam int OP_W   = 4;

    localparam logic [OP_W-1:0] OP_AND  = 4'd0;
    localparam logic [OP_W-1:0] OP_OR   = 4'd1;
    localparam logic [OP_W-1:0] OP_XOR  = 4'd2;
    localparam logic [OP_W-1:0] OP_CAS  = 4'd3;
    localparam logic [OP_W-1:0] OP_EXCH = 4'd4;
    localparam logic [OP_W-1:0] OP_ADD  = 4'd5;
    localparam logic [OP_W-1:0] OP_SUB  = 4'd6;
    localparam logic [OP_W-1:0] OP_INC  = 4'd7;
    localparam logic [OP_W-1:0] OP_DEC  = 4'd8;
    localparam logic [OP_W-1:0] OP_MAX  = 4'd9;
    localparam logic [OP_W-1:0] OP_MIN  = 4'd10;
    localparam logic [OP_W-1:0] OP_LAST = OP_MIN;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_CALC,
        ST_WRITE
    } amo_state_e;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [WORD_W-1:0] opnd;
        logic [WORD_W-1:0] swap;
        logic              wide;
        logic              sgn;
        logic              ret;
    } amo_req_t;

    typedef struct packed {
        logic [WORD_W-1:0] value;
        logic              mismatch;
    } amo_res_t;

    function automatic logic op_legal(input logic [OP_W-1:0] op);
        return op <= OP_LAST;
    endfunction

    // Widen a word to a 65-bit key so a single signed compare serves both
    // widths and both signedness choices.
    function automatic logic [WORD_W:0] cmp_key(input logic [WORD_W-1:0] x,
                                                 input logic wide,
                                                 input logic sgn);
        logic [WORD_W:0] k;
        if (wide) begin
            k = {sgn & x[WORD_W-1], x};
        end else begin
            k = {{(WORD_W-HALF_W+1){sgn & x[HALF_W-1]}}, x[HALF_W-1:0]};
        end
        return k;
    endfunction

    function automatic amo_res_t amo_calc(input amo_req_t q,
                                          input logic [WORD_W-1:0] old);
        amo_res_t          res;
        logic [WORD_W-1:0] r;
        logic [WORD_W:0]   k_op;
        logic [WORD_W:0]   k_old;
        logic              eq;
        logic              gt;
        logic              lt;
        k_op  = cmp_key(q.opnd, q.wide, q.sgn);
        k_old = cmp_key(old, q.wide, q.sgn);
        eq    = (k_op == k_old);
        gt    = $signed(k_op) > $signed(k_old);
        lt    = $signed(k_op) < $signed(k_old);
        res.mismatch = 1'b0;
        case (q.op)
            OP_AND:  r = old & q.opnd;
            OP_OR:   r = old | q.opnd;
            OP_XOR:  r = old ^ q.opnd;
            OP_CAS: begin
                r = eq ? q.swap : old;
                res.mismatch = !eq;
            end
            OP_EXCH: r = q.opnd;
            OP_ADD:  r = old + q.opnd;
            OP_SUB:  r = old - q.opnd;
            OP_INC:  r = old + 64'd1;
            OP_DEC:  r = old - 64'd1;
            OP_MAX:  r = gt ? q.opnd : old;
            OP_MIN:  r = lt ? q.opnd : old;
            default: r = old;
        endcase
        res.value = q.wide ? r : {old[WORD_W-1:HALF_W], r[HALF_W-1:0]};
        return res;
    endfunction

endpackage

// File: rtl/amo_word_store.sv
module amo_word_store
    import amo_pkg::*;
#(
    parameter int DEPTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] words [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                words[w] <= '0;
            end else if (we && (addr == ADDR_W'(w))) begin
                words[w] <= wdata;
            end
        end
    end

    assign rdata = words[addr];

endmodule

// File: rtl/amo_alu.sv
module amo_alu
    import amo_pkg::*;
(
    input  amo_req_t          req,
    input  logic [WORD_W-1:0] old,
    output amo_res_t          res
);

    always_comb begin
        res = amo_calc(req, old);
    end

endmodule

// File: rtl/amo_cas_stats.sv
module amo_cas_stats #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cas_done,
    input  logic             cas_miss,
    output logic [CNT_W-1:0] tries,
    output logic [CNT_W-1:0] fails
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tries <= '0;
            fails <= '0;
        end else if (cas_done) begin
            tries <= tries + CNT_W'(1);
            if (cas_miss) begin
                fails <= fails + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/amo_ctrl.sv
module amo_ctrl
    import amo_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  amo_req_t          req_in,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              txn_cas_mode,
    output amo_req_t          req_q,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] old_q,
    input  amo_res_t          alu_res,
    output logic              cas_done,
    output logic              cas_miss,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_data,
    output logic              err_pulse,
    output logic              tbl_clr
);

    amo_state_e        state;
    logic [WORD_W-1:0] new_q;
    logic              miss_q;
    logic              take;
    logic              is_cas;

    assign req_ready = (state == ST_IDLE);
    assign take      = req_valid && req_ready;
    assign is_cas    = (req_q.op == OP_CAS);
    assign mem_we    = (state == ST_WRITE);
    assign mem_wdata = new_q;
    assign cas_done  = mem_we && is_cas;
    assign cas_miss  = miss_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            req_q    <= '0;
            mem_addr <= '0;
            old_q    <= '0;
            new_q    <= '0;
            miss_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (take && op_legal(req_in.op)) begin
                        req_q    <= req_in;
                        mem_addr <= req_addr;
                        state    <= ST_READ;
                    end
                end
                ST_READ: begin
                    old_q <= mem_rdata;
                    state <= ST_CALC;
                end
                ST_CALC: begin
                    new_q  <= alu_res.value;
                    miss_q <= alu_res.mismatch;
                    state  <= ST_WRITE;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            err_pulse <= 1'b0;
            tbl_clr   <= 1'b0;
        end else begin
            rsp_valid <= mem_we && req_q.ret;
            if (mem_we && req_q.ret) begin
                rsp_data <= req_q.wide ? old_q
                                       : {{(WORD_W-HALF_W){1'b0}}, old_q[HALF_W-1:0]};
            end
            err_pulse <= take && !op_legal(req_in.op);
            tbl_clr   <= cas_done && txn_cas_mode;
        end
    end

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
    import amo_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int CNT_W  = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [3:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [63:0]       req_opnd,
    input  logic [63:0]       req_swap,
    input  logic              req_wide,
    input  logic              req_signed,
    input  logic              req_ret,
    input  logic              txn_cas_mode,
    output logic              rsp_valid,
    output logic [63:0]       rsp_data,
    output logic              err_pulse,
    output logic              tbl_clr,
    output logic [CNT_W-1:0]  cas_tries,
    output logic [CNT_W-1:0]  cas_fails
);

    amo_req_t          req_in;
    amo_req_t          req_q;
    amo_res_t          alu_res;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_we;
    logic [WORD_W-1:0] mem_wdata;
    logic [WORD_W-1:0] mem_rdata;
    logic [WORD_W-1:0] old_q;
    logic              cas_done;
    logic              cas_miss;

    always_comb begin
        req_in.op   = req_op;
        req_in.opnd = req_opnd;
        req_in.swap = req_swap;
        req_in.wide = req_wide;
        req_in.sgn  = req_signed;
        req_in.ret  = req_ret;
    end

    amo_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_in       (req_in),
        .req_addr     (req_addr),
        .txn_cas_mode (txn_cas_mode),
        .req_q        (req_q),
        .mem_addr     (mem_addr),
        .mem_we       (mem_we),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata),
        .old_q        (old_q),
        .alu_res      (alu_res),
        .cas_done     (cas_done),
        .cas_miss     (cas_miss),
        .rsp_valid    (rsp_valid),
        .rsp_data     (rsp_data),
        .err_pulse    (err_pulse),
        .tbl_clr      (tbl_clr)
    );

    amo_alu alu_i (
        .req (req_q),
        .old (old_q),
        .res (alu_res)
    );

    amo_word_store #(.DEPTH(DEPTH)) store_i (
        .clk   (clk),
        .rst   (rst),
        .addr  (mem_addr),
        .we    (mem_we),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    amo_cas_stats #(.CNT_W(CNT_W)) stats_i (
        .clk      (clk),
        .rst      (rst),
        .cas_done (cas_done),
        .cas_miss (cas_miss),
        .tries    (cas_tries),
        .fails    (cas_fails)
    );

endmodule

// File: rtl/amo_rmw_chk.sv
module amo_rmw_chk
    import amo_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [3:0]       req_op,
    input logic             txn_cas_mode,
    input logic             rsp_valid,
    input logic             err_pulse,
    input logic             tbl_clr,
    input logic [CNT_W-1:0] cas_tries,
    input logic [CNT_W-1:0] cas_fails
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (req_ready && !rsp_valid && !err_pulse && !tbl_clr
                        && cas_tries == '0 && cas_fails == '0));

    // R11
    busy_after_take_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && op_legal(req_op)) |=> !req_ready);

    // R8
    rsp_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R9
    err_idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> (req_ready && !rsp_valid && !tbl_clr));

    // R10
    clr_needs_mode_chk: assert property (@(posedge clk) disable iff (rst)
        tbl_clr |-> $past(txn_cas_mode));

    // R4
    fail_with_try_chk: assert property (@(posedge clk) disable iff (rst)
        (cas_fails != $past(cas_fails)) |-> (cas_tries == $past(cas_tries) + CNT_W'(1)));

endmodule

bind atomic_rmw_unit amo_rmw_chk #(.CNT_W(CNT_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_op       (req_op),
    .txn_cas_mode (txn_cas_mode),
    .rsp_valid    (rsp_valid),
    .err_pulse    (err_pulse),
    .tbl_clr      (tbl_clr),
    .cas_tries    (cas_tries),
    .cas_fails    (cas_fails)
);

// File: tb/atomic_rmw_unit_tb_top.sv
`timescale 1ns/1ps
module atomic_rmw_unit_tb_top;

    localparam int DEPTH  = 16;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [3:0]        req_op = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [63:0]       req_opnd = '0;
    logic [63:0]       req_swap = '0;
    logic              req_wide = 1'b0;
    logic              req_signed = 1'b0;
    logic              req_ret = 1'b0;
    logic              txn_cas_mode = 1'b0;
    logic              rsp_valid;
    logic [63:0]       rsp_data;
    logic              err_pulse;
    logic              tbl_clr;
    logic [CNT_W-1:0]  cas_tries;
    logic [CNT_W-1:0]  cas_fails;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [63:0] model [DEPTH];
    int          m_tries = 0;
    int          m_fails = 0;

    always #10 clk = ~clk;

    atomic_rmw_unit #(.DEPTH(DEPTH), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_opnd(req_opnd),
        .req_swap(req_swap), .req_wide(req_wide), .req_signed(req_signed),
        .req_ret(req_ret), .txn_cas_mode(txn_cas_mode), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .err_pulse(err_pulse), .tbl_clr(tbl_clr),
        .cas_tries(cas_tries), .cas_fails(cas_fails)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference behaviour written per width with native signed types.
    function automatic logic [63:0] ref_next(input logic [3:0] op,
            input logic [63:0] old, input logic [63:0] a, input logic [63:0] s,
            input bit wide, input bit sgn, output bit miss);
        logic [31:0] o32;
        logic [31:0] a32;
        logic [31:0] r32;
        logic [63:0] r64;
        bit gt;
        bit lt;
        miss = 1'b0;
        if (wide) begin
            gt = sgn ? ($signed(a) > $signed(old)) : (a > old);
            lt = sgn ? ($signed(a) < $signed(old)) : (a < old);
            case (op)
                4'd0: r64 = old & a;
                4'd1: r64 = old | a;
                4'd2: r64 = old ^ a;
                4'd3: begin miss = (old != a); r64 = miss ? old : s; end
                4'd4: r64 = a;
                4'd5: r64 = old + a;
                4'd6: r64 = old - a;
                4'd7: r64 = old + 1;
                4'd8: r64 = old - 1;
                4'd9: r64 = gt ? a : old;
                4'd10: r64 = lt ? a : old;
                default: r64 = old;
            endcase
            return r64;
        end
        o32 = old[31:0];
        a32 = a[31:0];
        gt = sgn ? ($signed(a32) > $signed(o32)) : (a32 > o32);
        lt = sgn ? ($signed(a32) < $signed(o32)) : (a32 < o32);
        case (op)
            4'd0: r32 = o32 & a32;
            4'd1: r32 = o32 | a32;
            4'd2: r32 = o32 ^ a32;
            4'd3: begin miss = (o32 != a32); r32 = miss ? o32 : s[31:0]; end
            4'd4: r32 = a32;
            4'd5: r32 = o32 + a32;
            4'd6: r32 = o32 - a32;
            4'd7: r32 = o32 + 1;
            4'd8: r32 = o32 - 1;
            4'd9: r32 = gt ? a32 : o32;
            4'd10: r32 = lt ? a32 : o32;
            default: r32 = o32;
        endcase
        return {old[63:32], r32};
    endfunction

    task automatic run_op(input logic [3:0] op, input int addr,
                          input logic [63:0] a, input logic [63:0] s,
                          input bit wide, input bit sgn, input bit ret,
                          input bit mode, input string tag);
        logic [63:0] old;
        logic [63:0] nxt;
        logic [63:0] exp_rsp;
        bit miss;
        bit legal;
        legal = (op <= 4'd10);
        old = model[addr];
        nxt = ref_next(op, old, a, s, wide, sgn, miss);
        exp_rsp = wide ? old : {32'h0, old[31:0]};
        @(negedge clk);
        req_op = op; req_addr = ADDR_W'(addr); req_opnd = a; req_swap = s;
        req_wide = wide; req_signed = sgn; req_ret = ret; txn_cas_mode = mode;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (!legal) begin
            // R9
            check(err_pulse === 1'b1 && req_ready === 1'b1 && rsp_valid === 1'b0,
                  {tag, " R9 reject"}, {61'd0, err_pulse, req_ready, rsp_valid}, 64'd6);
            @(negedge clk);
            check(err_pulse === 1'b0, {tag, " R9 one cycle"}, {63'd0, err_pulse}, 64'd0);
            return;
        end
        // R11
        check(req_ready === 1'b0, {tag, " R11 busy"}, {63'd0, req_ready}, 64'd0);
        check(err_pulse === 1'b0, {tag, " R9 no error on legal"}, {63'd0, err_pulse}, 64'd0);
        @(negedge clk);
        @(negedge clk);
        check(rsp_valid === 1'b0, {tag, " R8 not early"}, {63'd0, rsp_valid}, 64'd0);
        @(negedge clk);
        model[addr] = nxt;
        if (op == 4'd3) begin
            m_tries++;
            if (miss) m_fails++;
        end
        // R8
        check(rsp_valid === ret, {tag, " R8 valid"}, {63'd0, rsp_valid}, {63'd0, ret});
        if (ret) check(rsp_data === exp_rsp, {tag, " R8 data"}, rsp_data, exp_rsp);
        // R10
        check(tbl_clr === (mode && op == 4'd3), {tag, " R10 clear"},
              {63'd0, tbl_clr}, {63'd0, mode && op == 4'd3});
        // R4
        check(cas_tries === CNT_W'(m_tries) && cas_fails === CNT_W'(m_fails),
              {tag, " R4 counters"}, {32'(cas_tries), 32'(cas_fails)},
              {32'(m_tries), 32'(m_fails)});
        @(negedge clk);
        check(rsp_valid === 1'b0 && tbl_clr === 1'b0, {tag, " R8 R10 single pulse"},
              {62'd0, rsp_valid, tbl_clr}, 64'd0);
    endtask

    // Reads a word back through the normal port with an OR of zero.
    task automatic peek(input int addr, input string tag);
        run_op(4'd1, addr, 64'd0, 64'd0, 1'b1, 1'b0, 1'b1, 1'b0, tag);
    endtask

    initial begin
        #(20ns * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = 64'd0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(req_ready === 1'b1 && rsp_valid === 1'b0 && err_pulse === 1'b0 &&
              tbl_clr === 1'b0 && cas_tries === '0 && cas_fails === '0,
              "R1 reset outputs", {59'd0, req_ready, rsp_valid, err_pulse, tbl_clr, |cas_tries},
              64'd16);
        peek(3, "R1 word zero");

        // R2 basic and wrap
        run_op(4'd4, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 0, 1, 0, "R2 exch");
        run_op(4'd5, 0, 64'd2, 0, 1, 0, 1, 0, "R2 add wrap");
        peek(0, "R2 after wrap");
        run_op(4'd6, 1, 64'd5, 0, 1, 0, 0, 0, "R2 sub wrap");
        peek(1, "R2 sub readback");
        run_op(4'd2, 1, 64'h00FF_00FF_00FF_00FF, 0, 1, 0, 1, 0, "R2 xor");
        run_op(4'd0, 1, 64'h0F0F_0F0F_0F0F_0F0F, 0, 1, 0, 1, 0, "R2 and");

        // R3 and R4, R10
        run_op(4'd4, 2, 64'h1234, 0, 1, 0, 0, 0, "R3 setup");
        run_op(4'd3, 2, 64'h1234, 64'hABCD, 1, 0, 1, 1, "R3 cas match");
        run_op(4'd3, 2, 64'h1234, 64'h9999, 1, 0, 1, 1, "R3 cas miss");
        run_op(4'd3, 2, 64'hABCD, 64'h7777, 1, 0, 1, 0, "R10 cas mode off");
        peek(2, "R3 readback");

        // R5 operand ignored
        run_op(4'd7, 4, 64'h5555, 0, 1, 0, 1, 0, "R5 inc");
        run_op(4'd8, 4, 64'h5555, 0, 1, 0, 1, 0, "R5 dec");
        run_op(4'd8, 4, 64'h5555, 0, 1, 0, 1, 0, "R5 dec wrap");
        peek(4, "R5 readback");

        // R6 strict and signed
        run_op(4'd4, 5, 64'd10, 0, 1, 0, 0, 0, "R6 setup");
        run_op(4'd9, 5, 64'd10, 0, 1, 0, 1, 0, "R6 max equal");
        run_op(4'd9, 5, 64'hFFFF_FFFF_FFFF_FFF0, 0, 1, 1, 1, 0, "R6 max signed neg");
        run_op(4'd9, 5, 64'hFFFF_FFFF_FFFF_FFF0, 0, 1, 0, 1, 0, "R6 max unsigned");
        run_op(4'd10, 5, 64'd3, 0, 1, 1, 1, 0, "R6 min signed");
        peek(5, "R6 readback");

        // R7 narrow width
        run_op(4'd4, 6, 64'hAAAA_BBBB_FFFF_FFFF, 0, 1, 0, 0, 0, "R7 setup");
        run_op(4'd7, 6, 0, 0, 0, 0, 1, 0, "R7 inc narrow wrap");
        peek(6, "R7 upper kept");
        run_op(4'd3, 6, 64'h1111_1111_0000_0000, 64'h2222_2222_0000_0042, 0, 0, 1, 1,
               "R7 cas low compare");
        run_op(4'd9, 6, 64'h0000_0000_8000_0000, 0, 0, 1, 1, 0, "R7 max narrow signed");
        peek(6, "R7 final");

        // R9 illegal codes leave state
        run_op(4'd11, 6, 64'hDEAD, 0, 1, 0, 1, 1, "R9 code 11");
        run_op(4'd15, 6, 64'hDEAD, 0, 1, 0, 1, 1, "R9 code 15");
        peek(6, "R9 word intact");

        for (int n = 0; n < 400; n++) begin
            logic [3:0] op;
            int sel;
            sel = int'($urandom_range(0, 19));
            op = (sel > 16) ? 4'(11 + (sel - 17)) : 4'(sel % 11);
            run_op(op, int'($urandom_range(0, 7)),
                   ($urandom_range(0, 3) == 0) ? model[0] : {$urandom, $urandom},
                   {$urandom, $urandom}, 1'($urandom), 1'($urandom),
                   1'($urandom), 1'($urandom), "R2 random");
        end
        for (int i = 0; i < 8; i++) peek(i, "R2 final sweep");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule